// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block works out the 16-bit effective address of a memory operand for an 8-bit processor core. A one-cycle start pulse names the addressing mode (page-relative, absolute or postbyte-indexed). The block then pulls the operand bytes it needs from the instruction stream over a valid/ready byte port. When an indexed form asks for indirection, it performs one 16-bit read through a request/acknowledge memory port. It ends with a one-cycle done pulse. That pulse carries the final address, the number of extra cycles the form costs and, for auto-increment and auto-decrement forms, a write-back of the updated index register.

The surrounding core supplies four index registers, the two 8-bit accumulators, the page register and the program counter. The core must hold these stable from start until done. `pc_in` is the address of the first operand byte (the postbyte or the page offset). The block does not decode opcodes, move operand data or run the ALU.

Top module: `idx_ea_unit`

## Requirements
- R1: Mode 00 (page-relative) takes one byte, and the address is {dpage, byte}. xtra is 0.
- R2: Mode 01 (absolute) takes two bytes, most significant byte first, and the address is {first, second}. xtra is 0.
- R3: In mode 10 the first byte is the postbyte, and bits 6:5 choose the base (00 idx_x, 01 idx_y, 10 idx_u, 11 idx_s). When bit 7 is 0, the address is the base plus bits 4:0 taken as a signed 5-bit value, and xtra is 1.
- R4: With bit 7 set, the low nibble selects the form. 0000 gives address=base, write-back base+1, xtra 2. 0001 gives address=base, write-back base+2, xtra 3. 0010 gives address and write-back base-1, xtra 2. 0011 gives address and write-back base-2, xtra 3. The write-back appears as wb_en with done, wb_sel equal to postbyte bits 6:5 and wb_val.
- R5: Register offsets use the low nibble as follows. 0100 adds no offset (xtra 0). 0101 adds sign-extended acc_b (xtra 1). 0110 adds sign-extended acc_a (xtra 1). 1011 adds {acc_a, acc_b} (xtra 4).
- R6: Fetched offsets use the low nibble as follows. 1000 adds one further byte, sign-extended (xtra 1). 1001 adds a further two-byte word, most significant byte first (xtra 4).
- R7: Forms 1100 (one signed byte) and 1101 (two-byte word) add the offset to the program counter after all operand bytes. That counter value is pc_in plus the number of bytes the block took. xtra is 1.
- R8: With bit 7 set, postbyte bit 4 requests indirection. The block raises mem_req with mem_addr set to the computed address and holds both until mem_ack. The final address is mem_rdata, whose bits 15:8 are the byte at mem_addr. xtra grows by 3.
- R9: The following cases end with done, illegal=1, ea=16'hFFFF, xtra 0, no write-back, no memory read and no further bytes taken: nibbles 0111, 1010, 1110 and 1111; indirection with nibble 0000 or 0010; and mode 11.
- R10: done is high for exactly one cycle per operation, and wb_en is never high without done. All address and write-back sums wrap modulo 2^16.
- R11: A byte is taken only in a cycle with byte_valid and byte_ready both high. The block takes exactly as many bytes as the form needs. byte_ready is never high together with mem_req or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode | input | 2 | 00 page, 01 absolute, 10 indexed, 11 invalid |
| byte_valid | input | 1 | Instruction byte available |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 16 | Indirect read address |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Read word, high byte from mem_addr |
| idx_x | input | 16 | Index register, select 00 |
| idx_y | input | 16 | Index register, select 01 |
| idx_u | input | 16 | Index register, select 10 |
| idx_s | input | 16 | Index register, select 11 |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| dpage | input | 8 | Page register |
| pc_in | input | 16 | Address of first operand byte |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address (valid with done) |
| xtra | output | CYC_W | Extra cycle count (valid with done) |
| illegal | output | 1 | Invalid form (valid with done) |
| wb_en | output | 1 | Index register write-back strobe |
| wb_sel | output | 2 | Register to write back |
| wb_val | output | 16 | Write-back value |

## Verification
The bench builds the block with the default CYC_W of 4. That width holds the largest cost, 7, reached by a 16-bit offset with indirection, so every cost value is observable at the port without truncation. Random postbytes cover every nibble with and without the indirect bit. Byte and acknowledge gaps are random, and they exercise stalls in each fetch state and in the read wait. Directed cases hit the wrap at FFFF, negative 5-bit offsets and each invalid code.

// File: rtl/idx_ea_unit.sv
module idx_ea_unit #(
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             mem_req,
  output logic [15:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [15:0]      mem_rdata,
  input  logic [15:0]      idx_x,
  input  logic [15:0]      idx_y,
  input  logic [15:0]      idx_u,
  input  logic [15:0]      idx_s,
  input  logic [7:0]       acc_a,
  input  logic [7:0]       acc_b,
  input  logic [7:0]       dpage,
  input  logic [15:0]      pc_in,
  output logic             done,
  output logic [15:0]      ea,
  output logic [CYC_W-1:0] xtra,
  output logic             illegal,
  output logic             wb_en,
  output logic [1:0]       wb_sel,
  output logic [15:0]      wb_val
);

  localparam logic [1:0] M_PAGE = 2'b00, M_ABS = 2'b01, M_IDX = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_PB, S_OPND, S_CALC, S_IND, S_FIN} st_t;

  st_t             st;
  logic [1:0]      mode_q, rem_q;
  logic [7:0]      pb_q;
  logic [15:0]     opnd_q, pc_q, ea_q, ptr_q, wbv_q;
  logic            ill_q, wbe_q;
  logic [CYC_W-1:0] xtra_q;

  logic [15:0]     base, c_ea, c_wbv;
  logic            c_wbe;
  logic [CYC_W-1:0] c_cyc;

  function automatic logic form_ok(input logic [7:0] p);
    if (!p[7]) return 1'b1;
    case (p[3:0])
      4'b0111, 4'b1010, 4'b1110, 4'b1111: return 1'b0;
      4'b0000, 4'b0010:                   return !p[4];
      default:                            return 1'b1;
    endcase
  endfunction

  function automatic logic [1:0] form_len(input logic [7:0] p);
    if (!p[7]) return 2'd0;
    case (p[3:0])
      4'b1000, 4'b1100: return 2'd1;
      4'b1001, 4'b1101: return 2'd2;
      default:          return 2'd0;
    endcase
  endfunction

  assign byte_ready = (st == S_PB) || (st == S_OPND);
  assign mem_req    = (st == S_IND);
  assign mem_addr   = ptr_q;
  assign done       = (st == S_FIN);
  assign ea         = ea_q;
  assign xtra       = xtra_q;
  assign illegal    = ill_q;
  assign wb_en      = done && wbe_q;
  assign wb_sel     = pb_q[6:5];
  assign wb_val     = wbv_q;

  always_comb begin
    case (pb_q[6:5])
      2'b00:   base = idx_x;
      2'b01:   base = idx_y;
      2'b10:   base = idx_u;
      default: base = idx_s;
    endcase
  end

  always_comb begin
    c_ea  = base;
    c_wbv = base;
    c_wbe = 1'b0;
    c_cyc = '0;
    if (mode_q == M_PAGE) begin
      c_ea = {dpage, opnd_q[7:0]};
    end else if (mode_q == M_ABS) begin
      c_ea = opnd_q;
    end else if (!pb_q[7]) begin
      c_ea  = base + {{11{pb_q[4]}}, pb_q[4:0]};
      c_cyc = CYC_W'(1);
    end else begin
      case (pb_q[3:0])
        4'b0000: begin c_wbe = 1'b1; c_wbv = base + 16'd1; c_cyc = CYC_W'(2); end
        4'b0001: begin c_wbe = 1'b1; c_wbv = base + 16'd2; c_cyc = CYC_W'(3); end
        4'b0010: begin c_wbe = 1'b1; c_ea = base - 16'd1; c_wbv = base - 16'd1; c_cyc = CYC_W'(2); end
        4'b0011: begin c_wbe = 1'b1; c_ea = base - 16'd2; c_wbv = base - 16'd2; c_cyc = CYC_W'(3); end
        4'b0101: begin c_ea = base + {{8{acc_b[7]}}, acc_b}; c_cyc = CYC_W'(1); end
        4'b0110: begin c_ea = base + {{8{acc_a[7]}}, acc_a}; c_cyc = CYC_W'(1); end
        4'b1000: begin c_ea = base + {{8{opnd_q[7]}}, opnd_q[7:0]}; c_cyc = CYC_W'(1); end
        4'b1001: begin c_ea = base + opnd_q; c_cyc = CYC_W'(4); end
        4'b1011: begin c_ea = base + {acc_a, acc_b}; c_cyc = CYC_W'(4); end
        4'b1100: begin c_ea = pc_q + {{8{opnd_q[7]}}, opnd_q[7:0]}; c_cyc = CYC_W'(1); end
        4'b1101: begin c_ea = pc_q + opnd_q; c_cyc = CYC_W'(1); end
        default: ;
      endcase
      if (pb_q[4]) c_cyc = c_cyc + CYC_W'(3);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= '0;
      rem_q  <= '0;
      pb_q   <= '0;
      opnd_q <= '0;
      pc_q   <= '0;
      ea_q   <= '0;
      ptr_q  <= '0;
      wbv_q  <= '0;
      ill_q  <= 1'b0;
      wbe_q  <= 1'b0;
      xtra_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          pc_q   <= pc_in;
          ill_q  <= 1'b0;
          wbe_q  <= 1'b0;
          case (mode)
            M_PAGE: begin rem_q <= 2'd1; st <= S_OPND; end
            M_ABS:  begin rem_q <= 2'd2; st <= S_OPND; end
            M_IDX:  st <= S_PB;
            default: begin ill_q <= 1'b1; ea_q <= '1; xtra_q <= '0; st <= S_FIN; end
          endcase
        end
        S_PB: if (byte_valid) begin
          pb_q <= byte_data;
          pc_q <= pc_q + 16'd1;
          if (!form_ok(byte_data)) begin
            ill_q  <= 1'b1;
            ea_q   <= '1;
            xtra_q <= '0;
            st     <= S_FIN;
          end else if (form_len(byte_data) == 2'd0) begin
            st <= S_CALC;
          end else begin
            rem_q <= form_len(byte_data);
            st    <= S_OPND;
          end
        end
        S_OPND: if (byte_valid) begin
          opnd_q <= {opnd_q[7:0], byte_data};
          pc_q   <= pc_q + 16'd1;
          rem_q  <= rem_q - 2'd1;
          if (rem_q == 2'd1) st <= S_CALC;
        end
        S_CALC: begin
          xtra_q <= c_cyc;
          wbe_q  <= c_wbe;
          wbv_q  <= c_wbv;
          if (mode_q == M_IDX && pb_q[7] && pb_q[4]) begin
            ptr_q <= c_ea;
            st    <= S_IND;
          end else begin
            ea_q <= c_ea;
            st   <= S_FIN;
          end
        end
        S_IND: if (mem_ack) begin
          ea_q <= mem_rdata;
          st   <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!wb_en && ea == 16'hFFFF));
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r11_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (!mem_req && !done));
  a_r4_cost_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (xtra <= CYC_W'(7)));

endmodule

// File: tb/idx_ea_unit_test.sv
module idx_ea_unit_test;
  localparam int CYC_W = 4;

  logic clk = 0, rst_n = 0;
  logic start = 0, byte_valid = 0, mem_ack = 0;
  logic [1:0] mode = 0;
  logic [7:0] byte_data = 0, acc_a = 0, acc_b = 0, dpage = 0;
  logic [15:0] mem_rdata = 0, idx_x = 0, idx_y = 0, idx_u = 0, idx_s = 0, pc_in = 0;
  logic byte_ready, mem_req, done, illegal, wb_en;
  logic [15:0] mem_addr, ea, wb_val;
  logic [CYC_W-1:0] xtra;
  logic [1:0] wb_sel;

  int checks = 0, errors = 0;
  bit hung = 0;

  always #10 clk = ~clk;

  idx_ea_unit #(.CYC_W(CYC_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .idx_x(idx_x), .idx_y(idx_y), .idx_u(idx_u), .idx_s(idx_s),
    .acc_a(acc_a), .acc_b(acc_b), .dpage(dpage), .pc_in(pc_in),
    .done(done), .ea(ea), .xtra(xtra), .illegal(illegal),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val));

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] + 8'h5B};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] md, input logic [7:0] b0, b1, b2,
                       output logic [15:0] e, output int cyc, output bit ill,
                       output bit wbe, output logic [15:0] wbv, output int nb,
                       output bit ind, output logic [15:0] ptr, output string tag);
    logic [15:0] r;
    logic [3:0] n;
    e = 0; cyc = 0; ill = 0; wbe = 0; wbv = 0; nb = 0; ind = 0; ptr = 0; tag = "R9";
    case (b0[6:5])
      2'b00: r = idx_x;
      2'b01: r = idx_y;
      2'b10: r = idx_u;
      default: r = idx_s;
    endcase
    n = b0[3:0];
    if (md == 2'b00) begin e = {dpage, b0}; nb = 1; tag = "R1"; end
    else if (md == 2'b01) begin e = {b0, b1}; nb = 2; tag = "R2"; end
    else if (md == 2'b11) begin ill = 1; e = 16'hFFFF; end
    else begin
      nb = 1;
      if (!b0[7]) begin e = r + {{11{b0[4]}}, b0[4:0]}; cyc = 1; tag = "R3"; end
      else begin
        case (n)
          4'h0: begin e = r; wbe = 1; wbv = r + 16'd1; cyc = 2; tag = "R4"; end
          4'h1: begin e = r; wbe = 1; wbv = r + 16'd2; cyc = 3; tag = "R4"; end
          4'h2: begin e = r - 16'd1; wbe = 1; wbv = e; cyc = 2; tag = "R4"; end
          4'h3: begin e = r - 16'd2; wbe = 1; wbv = e; cyc = 3; tag = "R4"; end
          4'h4: begin e = r; cyc = 0; tag = "R5"; end
          4'h5: begin e = r + {{8{acc_b[7]}}, acc_b}; cyc = 1; tag = "R5"; end
          4'h6: begin e = r + {{8{acc_a[7]}}, acc_a}; cyc = 1; tag = "R5"; end
          4'hB: begin e = r + {acc_a, acc_b}; cyc = 4; tag = "R5"; end
          4'h8: begin nb = 2; e = r + {{8{b1[7]}}, b1}; cyc = 1; tag = "R6"; end
          4'h9: begin nb = 3; e = r + {b1, b2}; cyc = 4; tag = "R6"; end
          4'hC: begin nb = 2; e = pc_in + 16'd2 + {{8{b1[7]}}, b1}; cyc = 1; tag = "R7"; end
          4'hD: begin nb = 3; e = pc_in + 16'd3 + {b1, b2}; cyc = 1; tag = "R7"; end
          default: ill = 1;
        endcase
        if ((n == 4'h0 || n == 4'h2) && b0[4]) ill = 1;
        if (ill) begin e = 16'hFFFF; cyc = 0; wbe = 0; nb = 1; tag = "R9"; end
        else if (b0[4]) begin ind = 1; ptr = e; e = mem_word(ptr); cyc += 3; tag = "R8"; end
      end
    end
  endtask

  task automatic run_op(input logic [1:0] md, input logic [7:0] b0, b1, b2);
    logic [7:0] bs [3];
    logic [15:0] e, wbv, ptr, seen_addr;
    int cyc, nb, idx, cycles;
    bit ill, wbe, ind, got, mem_seen;
    string tag;
    logic [15:0] r_ea, r_wbv;
    logic [CYC_W-1:0] r_x;
    logic r_ill, r_wbe;
    logic [1:0] r_sel;
    if (hung) return;
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    model(md, b0, b1, b2, e, cyc, ill, wbe, wbv, nb, ind, ptr, tag);
    @(negedge clk); start = 1; mode = md;
    @(negedge clk); start = 0;
    idx = 0; cycles = 0; got = 0; mem_seen = 0; seen_addr = 0;
    r_ea = 0; r_wbv = 0; r_x = 0; r_ill = 0; r_wbe = 0; r_sel = 0;
    while (!got && cycles < 300) begin
      byte_valid = (idx < 3) && ($urandom % 4 != 0);
      byte_data = (idx < 3) ? bs[idx] : 8'h00;
      mem_ack = mem_req && ($urandom % 3 == 0);
      mem_rdata = mem_word(mem_addr);
      if (mem_req) begin mem_seen = 1; seen_addr = mem_addr; end
      if (byte_valid && byte_ready) idx++;
      if (done) begin
        got = 1; r_ea = ea; r_x = xtra; r_ill = illegal; r_wbe = wb_en; r_sel = wb_sel; r_wbv = wb_val;
      end
      @(negedge clk); cycles++;
    end
    byte_valid = 0; mem_ack = 0;
    if (!got) begin
      hung = 1;
      chk(0, tag, "watchdog no done", 0, 1);
      return;
    end
    chk(!done, "R10", "done second cycle", 32'(done), 0);
    chk(r_ill == ill, tag, "illegal", 32'(r_ill), 32'(ill));
    chk(r_ea == e, tag, "ea", 32'(r_ea), 32'(e));
    chk(r_x == CYC_W'(cyc), tag, "xtra", 32'(r_x), 32'(cyc));
    chk(r_wbe == wbe, tag, "wb_en", 32'(r_wbe), 32'(wbe));
    if (wbe) begin
      chk(r_sel == b0[6:5], "R4", "wb_sel", 32'(r_sel), 32'(b0[6:5]));
      chk(r_wbv == wbv, "R4", "wb_val", 32'(r_wbv), 32'(wbv));
    end
    chk(idx == nb, "R11", "bytes taken", 32'(idx), 32'(nb));
    chk(mem_seen == ind, "R8", "memory read issued", 32'(mem_seen), 32'(ind));
    if (ind) chk(seen_addr == ptr, "R8", "mem_addr", 32'(seen_addr), 32'(ptr));
  endtask

  task automatic rand_regs();
    idx_x = 16'($urandom); idx_y = 16'($urandom); idx_u = 16'($urandom); idx_s = 16'($urandom);
    acc_a = 8'($urandom); acc_b = 8'($urandom); dpage = 8'($urandom); pc_in = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!done && !byte_ready && !mem_req && !wb_en, "R10", "reset outputs quiet",
        {done, byte_ready, mem_req, wb_en}, 0);
    rst_n = 1;
    @(negedge clk);

    rand_regs();
    idx_x = 16'hFFFF;
    run_op(2'b10, 8'h80, 8'h00, 8'h00);
    idx_y = 16'h0000;
    run_op(2'b10, 8'h3F, 8'h00, 8'h00);
    idx_s = 16'h0001;
    run_op(2'b10, 8'hE3, 8'h00, 8'h00);
    run_op(2'b10, 8'hB9, 8'h80, 8'h01);
    run_op(2'b10, 8'h9D, 8'hFF, 8'hF0);
    run_op(2'b10, 8'h90, 8'h00, 8'h00);
    run_op(2'b10, 8'h92, 8'h00, 8'h00);
    run_op(2'b10, 8'h87, 8'h00, 8'h00);
    run_op(2'b10, 8'hAA, 8'h00, 8'h00);
    run_op(2'b10, 8'hCE, 8'h00, 8'h00);
    run_op(2'b10, 8'hEF, 8'h00, 8'h00);
    run_op(2'b11, 8'h00, 8'h00, 8'h00);
    run_op(2'b00, 8'h7E, 8'h00, 8'h00);
    run_op(2'b01, 8'h12, 8'h34, 8'h00);
    pc_in = 16'hFFFE;
    run_op(2'b10, 8'h8C, 8'h05, 8'h00);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      rand_regs();
      md = ($urandom % 8 == 0) ? 2'($urandom) : 2'b10;
      run_op(md, 8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule